// File: doc/BRIEF.md
# Dual-Channel Disk Interrupt Combiner

This block merges the interrupt lines of two disk channels into one host interrupt. Each channel's line is sampled every clock. A rising edge latches a status bit. A falling edge clears that status bit and withdraws the channel's request from the host. Software sees the status bits and two per-channel block bits in one byte register on a small register port. It clears a status bit by writing a one to it. It sets or removes a block bit by plain writes.

The host output is the OR of two per-channel forwarded levels. A channel assertion raises its forwarded level only while that channel's block bit is clear. A channel deassertion always lowers the level, whatever the block bit holds. Writing the register never lowers a forwarded level. A write that leaves a channel's status set and its block bit clear raises that channel's forwarded level on the next clock, so removing a block re-raises a pending request.

Top module: `ide_irq_combiner`

## Requirements
- R1: After reset, the register reads 0x00 and `host_irq` is low.
- R2: One clock after a channel input is first sampled high, that channel's status bit reads 1. Channel 0 uses bit 2 and channel 1 uses bit 3.
- R3: One clock after a channel input is first sampled low, that channel's status bit reads 0 and its forwarded level is dropped, even when its block bit is set.
- R4: A channel assertion raises `host_irq` on the next clock only when that channel's block bit is 0. Channel 0 is blocked by bit 4 and channel 1 by bit 5. A blocked assertion leaves `host_irq` low unless the other channel is forwarding.
- R5: On a register write, a 1 in bit 2 or bit 3 clears the matching status bit. A 0 in those bits leaves it unchanged.
- R6: On a register write, bits 4 and 5 take the written values directly.
- R7: After a write, a channel whose status bit is still 1 and whose block bit is now 0 drives `host_irq` high on the next clock.
- R8: Setting a block bit or clearing a status bit by a write does not lower a forwarded level. Only a channel deassertion lowers it.
- R9: Register bits 0, 1, 6 and 7 read 0 and ignore writes. The register answers at offset 1 only. Other offsets read 0x00, and writes to them change nothing.
- R10: `host_irq` is the OR of the two forwarded levels. One channel falling leaves `host_irq` high while the other channel is forwarding.
- R11: A channel rise in the same clock as a write that clears that channel's status leaves the status bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register offset for read and write |
| reg_wr_en | input | 1 | Write strobe, one clock per write |
| reg_wr_data | input | 8 | Write data byte |
| reg_rd_data | output | 8 | Read data, combinational from reg_addr |
| chan_irq | input | 2 | Level interrupt line of each channel |
| host_irq | output | 1 | Merged host interrupt |

## Verification
The bench builds the block with its default parameters: two channels, a 4-bit offset, the register at offset 1 and status starting at bit 2. These values place the status, block and unused bits at fixed positions, so every write pattern can be checked against a literal byte. With them the bench reaches blocked rises, re-raising by removing a block, and the forwarded level staying high after its status bit is cleared. It also reaches a rise in the same clock as a clearing write, and one channel's fall while the other keeps the host line up.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;

  localparam int REG_W = 8;

  // Next status bit: an edge on the line wins over a software clear.
  function automatic logic stat_next(logic cur, logic clr, logic rise, logic fall);
    logic after_wr;
    after_wr = cur & ~clr;
    if (rise)      return 1'b1;
    else if (fall) return 1'b0;
    else           return after_wr;
  endfunction

  // Next forwarded level of one channel.
  function automatic logic fwd_next(logic cur, logic rise, logic fall, logic wr,
                                    logic stat_n, logic mask_n);
    if (fall)                       return 1'b0;
    else if (rise && !mask_n)       return 1'b1;
    else if (wr && stat_n && !mask_n) return 1'b1;
    else                            return cur;
  endfunction

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] lvl_in,
  output logic [NUM_CH-1:0] rise_o,
  output logic [NUM_CH-1:0] fall_o
);
  logic [NUM_CH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_in;
  end

  assign rise_o = lvl_in & ~prev_q;
  assign fall_o = ~lvl_in & prev_q;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [NUM_CH-1:0] wr_mask,
  output logic [NUM_CH-1:0] mask_q,
  output logic [NUM_CH-1:0] mask_n
);
  assign mask_n = wr_hit ? wr_mask : mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_n;
  end
endmodule

// File: rtl/irq_chan_slice.sv
module irq_chan_slice
  import ide_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic fall,
  input  logic wr_hit,
  input  logic clr_bit,
  input  logic mask_n,
  output logic stat_q,
  output logic fwd_q
);
  logic stat_d;
  logic fwd_d;

  always_comb begin
    stat_d = stat_next(stat_q, wr_hit & clr_bit, rise, fall);
    fwd_d  = fwd_next(fwd_q, rise, fall, wr_hit, stat_d, mask_n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      fwd_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      fwd_q  <= fwd_d;
    end
  end
endmodule

// File: rtl/ide_irq_combiner.sv
module ide_irq_combiner
  import ide_irq_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int ADDR_W     = 4,
  parameter int REG_OFFSET = 1,
  parameter int STAT_LSB   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [REG_W-1:0]  reg_wr_data,
  output logic [REG_W-1:0]  reg_rd_data,
  input  logic [NUM_CH-1:0] chan_irq,
  output logic              host_irq
);
  localparam int MASK_LSB = STAT_LSB + NUM_CH;

  // Named internal events, brought out for the checker.
  logic              addr_hit;
  logic              wr_hit;
  logic [NUM_CH-1:0] rise_evt;
  logic [NUM_CH-1:0] fall_evt;
  logic [NUM_CH-1:0] stat_q;
  logic [NUM_CH-1:0] fwd_q;
  logic [NUM_CH-1:0] mask_q;
  logic [NUM_CH-1:0] mask_n;
  logic [NUM_CH-1:0] clr_bits;
  logic [REG_W-1:0]  reg_image;
  logic              unused_wr_bits;

  assign addr_hit = (reg_addr == ADDR_W'(REG_OFFSET));
  assign wr_hit   = reg_wr_en & addr_hit;
  assign clr_bits = reg_wr_data[STAT_LSB +: NUM_CH];
  assign unused_wr_bits = ^reg_wr_data;

  irq_edge_det #(.NUM_CH(NUM_CH)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_in(chan_irq),
    .rise_o(rise_evt), .fall_o(fall_evt)
  );

  irq_mask_reg #(.NUM_CH(NUM_CH)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit),
    .wr_mask(reg_wr_data[MASK_LSB +: NUM_CH]),
    .mask_q(mask_q), .mask_n(mask_n)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    irq_chan_slice u_slice (
      .clk(clk), .rst_n(rst_n),
      .rise(rise_evt[c]), .fall(fall_evt[c]),
      .wr_hit(wr_hit), .clr_bit(clr_bits[c]), .mask_n(mask_n[c]),
      .stat_q(stat_q[c]), .fwd_q(fwd_q[c])
    );
  end

  always_comb begin
    reg_image = '0;
    reg_image[STAT_LSB +: NUM_CH] = stat_q;
    reg_image[MASK_LSB +: NUM_CH] = mask_q;
  end

  assign reg_rd_data = addr_hit ? reg_image : '0;
  assign host_irq    = |fwd_q;
endmodule

// File: rtl/ide_irq_combiner_chk.sv
module ide_irq_combiner_chk #(
  parameter int NUM_CH   = 2,
  parameter int STAT_LSB = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_hit,
  input logic [7:0]        wr_data,
  input logic [NUM_CH-1:0] rise_evt,
  input logic [NUM_CH-1:0] fall_evt,
  input logic [NUM_CH-1:0] stat_q,
  input logic [NUM_CH-1:0] mask_q,
  input logic [NUM_CH-1:0] fwd_q,
  input logic              host_irq
);
  localparam int MASK_LSB = STAT_LSB + NUM_CH;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_rise_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rise_evt[c] |=> stat_q[c]);
    assert_fall_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fall_evt[c] |=> (!stat_q[c] && !fwd_q[c]));
    assert_blocked_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_evt[c] && !wr_hit && mask_q[c] && !fwd_q[c]) |=> !fwd_q[c]);
    assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && wr_data[STAT_LSB+c] && !rise_evt[c]) |=> !stat_q[c]);
    assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (mask_q[c] == $past(wr_data[MASK_LSB+c])));
    assert_reassert_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && stat_q[c] && !wr_data[STAT_LSB+c] && !wr_data[MASK_LSB+c]
       && !fall_evt[c]) |=> host_irq);
    assert_level_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_q[c] && !fall_evt[c]) |=> fwd_q[c]);
  end
endmodule

bind ide_irq_combiner ide_irq_combiner_chk #(.NUM_CH(NUM_CH), .STAT_LSB(STAT_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wr_data(reg_wr_data),
  .rise_evt(rise_evt), .fall_evt(fall_evt), .stat_q(stat_q),
  .mask_q(mask_q), .fwd_q(fwd_q), .host_irq(host_irq)
);

// File: tb/sim_ide_irq_combiner.sv
module sim_ide_irq_combiner;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] reg_addr = 4'd1;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wr_data = 8'h00;
  logic [7:0] reg_rd_data;
  logic [1:0] chan_irq = 2'b00;
  logic       host_irq;

  int n_run = 0;
  int n_fail = 0;

  typedef struct {
    string      tag;
    logic [7:0] exp_reg;
    logic       exp_host;
  } exp_t;
  exp_t sb_q[$];

  // Independent reference state, per the requirements.
  logic [1:0] m_stat = 2'b00, m_blk = 2'b00, m_fwd = 2'b00, m_prev = 2'b00;

  always #5 clk = ~clk;

  ide_irq_combiner u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
    .chan_irq(chan_irq), .host_irq(host_irq)
  );

  task automatic check(string tag, logic [7:0] got_r, logic [7:0] exp_r,
                       logic got_h, logic exp_h);
    n_run++;
    if (got_r !== exp_r || got_h !== exp_h) begin
      n_fail++;
      $display("FAIL %s: reg=%02h host=%b expected reg=%02h host=%b",
               tag, got_r, got_h, exp_r, exp_h);
    end
  endtask

  // Driver: applies one clock of stimulus and pushes the expected result.
  task automatic step(string tag, logic [1:0] irq, logic wr, logic [3:0] addr,
                      logic [7:0] data);
    logic [1:0] rise, fall;
    exp_t e;
    @(negedge clk);
    chan_irq = irq; reg_wr_en = wr; reg_addr = addr; reg_wr_data = data;
    rise = irq & ~m_prev;
    fall = m_prev & ~irq;
    if (wr && addr == 4'd1) begin
      m_stat = m_stat & ~data[3:2];
      m_blk  = data[5:4];
    end
    for (int c = 0; c < 2; c++) begin
      if (rise[c]) m_stat[c] = 1'b1;
      if (fall[c]) m_stat[c] = 1'b0;
      if (fall[c]) m_fwd[c] = 1'b0;
      else if (rise[c] && !m_blk[c]) m_fwd[c] = 1'b1;
      else if (wr && addr == 4'd1 && m_stat[c] && !m_blk[c]) m_fwd[c] = 1'b1;
    end
    m_prev = irq;
    e.tag = tag;
    e.exp_reg = (addr == 4'd1) ? {2'b00, m_blk, m_stat, 2'b00} : 8'h00;
    e.exp_host = |m_fwd;
    sb_q.push_back(e);
  endtask

  // Monitor: compares after each capturing edge.
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.tag, reg_rd_data, e.exp_reg, host_irq, e.exp_host);
    end
  end

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: reg=%02h host=%b expected run to end", reg_rd_data, host_irq);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    check("R1 reset", reg_rd_data, 8'h00, host_irq, 1'b0);
    step("R2 R4 ch0 rise unblocked",     2'b01, 1'b0, 4'd1, 8'h00); // 0x04, host 1
    step("R2 ch0 held",                  2'b01, 1'b0, 4'd1, 8'h00);
    step("R5 R8 clear ch0 status",       2'b01, 1'b1, 4'd1, 8'h04); // 0x00, host 1
    step("R3 ch0 fall",                  2'b00, 1'b0, 4'd1, 8'h00); // host 0
    step("R6 block ch0",                 2'b00, 1'b1, 4'd1, 8'h10); // 0x10
    step("R4 blocked rise",              2'b01, 1'b0, 4'd1, 8'h00); // 0x14, host 0
    step("R7 unblock re-raises",         2'b01, 1'b1, 4'd1, 8'h00); // 0x04, host 1
    step("R8 block keeps level",         2'b01, 1'b1, 4'd1, 8'h10); // 0x14, host 1
    step("R3 fall while blocked",        2'b00, 1'b0, 4'd1, 8'h00); // 0x10, host 0
    step("R2 R4 ch1 rise",               2'b10, 1'b0, 4'd1, 8'h00); // 0x18, host 1
    step("R6 block ch1 unblock ch0",     2'b10, 1'b1, 4'd1, 8'h20); // 0x28
    step("R2 ch0 rise second",           2'b11, 1'b0, 4'd1, 8'h00); // 0x2C
    step("R10 ch1 fall ch0 holds",       2'b01, 1'b0, 4'd1, 8'h00); // 0x24, host 1
    step("R9 unused bits ignored",       2'b01, 1'b1, 4'd1, 8'hC3); // 0x04
    step("R9 other offset write",        2'b01, 1'b1, 4'd2, 8'hFF); // rd 0
    step("R9 register intact",           2'b01, 1'b0, 4'd1, 8'h00); // 0x04
    step("R3 ch0 fall",                  2'b00, 1'b0, 4'd1, 8'h00); // 0x00, host 0
    step("R11 rise with clear",          2'b10, 1'b1, 4'd1, 8'h08); // 0x08, host 1
    step("R5 clear ch1 held high",       2'b10, 1'b1, 4'd1, 8'h08); // 0x00, host 1
    step("R7 no status no raise",        2'b10, 1'b1, 4'd1, 8'h00); // 0x00, host 1
    step("R3 ch1 fall",                  2'b00, 1'b0, 4'd1, 8'h00); // host 0
    step("R7 empty write",               2'b00, 1'b1, 4'd1, 8'h00);
    repeat (3) @(posedge clk);
    #2;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule